// File: doc/BRIEF.md
# AAL1 Pointer-Byte Cell Sequencer

This block assembles the payload of successive outgoing AAL1 structured-data cells for a single virtual circuit. It keeps a 3-bit cell sequence count. For every cell it decides from a 4-bit one-hot select word whether the cell opens with a pointer byte. It then fills the rest of the payload with one byte per channel, visiting the circuit's channel entries in a fixed round-robin order.

Each channel entry owns a 64-byte circular buffer in external memory. The block keeps a 6-bit read index per entry, issues one read at a time on a request/valid memory port, and forwards each returned byte on a byte-stream output. The stream carries a pointer flag and a last-byte flag. The pointer value itself, cell headers and any checksum are supplied or added elsewhere. A new cell is requested with a one-cycle start strobe while the block is idle.

Top module: `aal1_cell_builder`

## Requirements
- R1: The sequence count `seqNum` is 0 after reset. It advances by one on the clock edge that emits the final byte of a cell, and it wraps from 7 to 0.
- R2: A cell whose sequence number is odd never carries a pointer byte, whatever the select word holds.
- R3: Select bit 3 enables a pointer in cell 0, bit 2 in cell 2, bit 1 in cell 4 and bit 0 in cell 6. So 0000 gives no pointers, 1000 gives one per 8 cells, 1010 gives cells 0 and 4, and 1111 gives every even cell.
- R4: A pointer cell first emits `ptrValue` with `outPtr`=1 and then PAYLOAD_BYTES-1 data bytes. Any other cell emits PAYLOAD_BYTES data bytes. `outLast` is 1 only on the final byte, and never on a pointer byte.
- R5: The first cell after reset starts fetching at `firstEntry`. Entries are then visited in increasing order up to `lastEntry`, after which the walk returns to `firstEntry`. The walk continues across cell boundaries. `curEntry` always shows the next entry due.
- R6: A fetch address is {entry[6:0], readIndex[5:0]}. Each entry's read index starts at 0, rises by one per byte fetched from that entry, and wraps modulo 64.
- R7: With `firstEntry` equal to `lastEntry`, every data byte is fetched from that single entry.
- R8: `memReq` is a one-cycle pulse, and at most one read is outstanding. A returned byte appears on `outData` with `outValid` in the cycle after `memValid`. A pointer byte appears two cycles after the start strobe is sampled.
- R9: A start strobe that arrives while `busy` is 1 is ignored and does not alter the byte stream.
- R10: During and right after reset, `busy`, `outValid` and `memReq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cellStart | input | 1 | Start-of-cell strobe, taken only when idle |
| ptrSelect | input | 4 | One-hot pointer enables for even cells |
| ptrValue | input | 8 | Pointer byte to insert |
| firstEntry | input | 7 | First channel entry of the circuit |
| lastEntry | input | 7 | Last channel entry of the circuit |
| memReq | output | 1 | Read request pulse |
| memAddr | output | 13 | Read byte address |
| memValid | input | 1 | Read data valid |
| memData | input | 8 | Read data |
| outValid | output | 1 | Output byte valid |
| outData | output | 8 | Output byte |
| outPtr | output | 1 | Output byte is a pointer |
| outLast | output | 1 | Final byte of the cell |
| busy | output | 1 | Cell in progress |
| seqNum | output | 3 | Cell sequence count |
| curEntry | output | 7 | Next channel entry to fetch |

## Verification
The first request appears one cycle after the start strobe is sampled, or two cycles after it when the cell carries a pointer. The pointer byte itself is due two cycles after the strobe. Each data byte is due one cycle after its `memValid`, and `seqNum` changes on the same edge as the final byte. The bench builds the expected address and byte sequences into queues when it raises the strobe. It then compares every `memReq` and every `outValid` cycle against the queue heads on the falling edge, so its checks hold for any memory latency. Once `busy` drops, the count, the entry pointer and the empty queues are checked one falling edge later.

// File: rtl/aal1_cell_pkg.sv
package aal1_cell_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PTR   = 2'd1,
    ST_FETCH = 2'd2,
    ST_WAIT  = 2'd3
  } cellState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic startCell;
    logic emitPtr;
    logic issueReq;
    logic takeData;
    logic lastByte;
  } cellStrobe_t;

endpackage

// File: rtl/aal1_cell_ctrl.sv
module aal1_cell_ctrl
  import aal1_cell_pkg::*;
#(
  parameter int SEQ_W         = 3,
  parameter int SEL_W         = 4,
  parameter int PAYLOAD_BYTES = 47
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cellStart,
  input  logic [SEL_W-1:0]  ptrSelect,
  input  logic              memValid,
  output cellStrobe_t       strobe,
  output logic              busy,
  output logic [SEQ_W-1:0]  seqNum
);

  localparam int REM_W  = $clog2(PAYLOAD_BYTES + 1);
  localparam int PAIR_W = (SEQ_W > 1) ? SEQ_W - 1 : 1;

  cellState_e        state, stateNext;
  logic [REM_W-1:0]  remain;
  logic [SEQ_W-1:0]  seqCnt;
  logic [PAIR_W-1:0] pairIdx;
  logic              selBit;
  logic              wantPtr;

  // even cells 0,2,4,6 map to select bits from MSB down
  assign pairIdx = seqCnt[SEQ_W-1:1];

  always_comb begin
    selBit = 1'b0;
    for (int k = 0; k < SEL_W; k++) begin
      if (pairIdx == PAIR_W'(k)) selBit = ptrSelect[SEL_W-1-k];
    end
  end

  assign wantPtr = ~seqCnt[0] & selBit;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (cellStart) begin
          strobe.startCell = 1'b1;
          stateNext        = wantPtr ? ST_PTR : ST_FETCH;
        end
      end
      ST_PTR: begin
        strobe.emitPtr = 1'b1;
        stateNext      = ST_FETCH;
      end
      ST_FETCH: begin
        strobe.issueReq = 1'b1;
        stateNext       = ST_WAIT;
      end
      ST_WAIT: begin
        if (memValid) begin
          strobe.takeData = 1'b1;
          strobe.lastByte = (remain == REM_W'(1));
          stateNext       = (remain == REM_W'(1)) ? ST_IDLE : ST_FETCH;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      remain <= '0;
      seqCnt <= '0;
    end else begin
      state <= stateNext;
      if (strobe.startCell) begin
        remain <= REM_W'(PAYLOAD_BYTES);
      end else if (strobe.emitPtr || strobe.takeData) begin
        remain <= remain - REM_W'(1);
      end
      if (strobe.lastByte) seqCnt <= seqCnt + SEQ_W'(1);
    end
  end

  assign busy   = (state != ST_IDLE);
  assign seqNum = seqCnt;

endmodule

// File: rtl/aal1_cell_datapath.sv
module aal1_cell_datapath
  import aal1_cell_pkg::*;
#(
  parameter int ENTRY_W   = 7,
  parameter int BUF_BYTES = 64,
  parameter int DATA_W    = 8
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  cellStrobe_t                            strobe,
  input  logic [ENTRY_W-1:0]                     firstEntry,
  input  logic [ENTRY_W-1:0]                     lastEntry,
  input  logic [DATA_W-1:0]                      ptrValue,
  input  logic [DATA_W-1:0]                      memData,
  output logic                                   memReq,
  output logic [ENTRY_W+$clog2(BUF_BYTES)-1:0]   memAddr,
  output logic                                   outValid,
  output logic [DATA_W-1:0]                      outData,
  output logic                                   outPtr,
  output logic                                   outLast,
  output logic [ENTRY_W-1:0]                     curEntry
);

  localparam int PTR_W       = $clog2(BUF_BYTES);
  localparam int NUM_ENTRIES = 1 << ENTRY_W;

  logic [PTR_W-1:0]   rdPtr [NUM_ENTRIES];
  logic [ENTRY_W-1:0] entryReg;
  logic               walkStarted;
  logic [ENTRY_W-1:0] entryNext;

  assign entryNext = (entryReg == lastEntry) ? firstEntry : entryReg + ENTRY_W'(1);

  // entry walk: first cell after reset loads the first entry
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      entryReg    <= '0;
      walkStarted <= 1'b0;
    end else begin
      if (strobe.startCell && !walkStarted) begin
        entryReg    <= firstEntry;
        walkStarted <= 1'b1;
      end else if (strobe.takeData) begin
        entryReg <= entryNext;
      end
    end
  end

  // one circular read index per channel entry
  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_chan
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rdPtr[e] <= '0;
      end else if (strobe.takeData && entryReg == ENTRY_W'(e)) begin
        rdPtr[e] <= rdPtr[e] + PTR_W'(1);
      end
    end
  end

  assign memReq  = strobe.issueReq;
  assign memAddr = {entryReg, rdPtr[entryReg]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outValid <= 1'b0;
      outData  <= '0;
      outPtr   <= 1'b0;
      outLast  <= 1'b0;
    end else begin
      outValid <= strobe.emitPtr | strobe.takeData;
      outPtr   <= strobe.emitPtr;
      outLast  <= strobe.takeData & strobe.lastByte;
      if (strobe.emitPtr) begin
        outData <= ptrValue;
      end else if (strobe.takeData) begin
        outData <= memData;
      end
    end
  end

  assign curEntry = entryReg;

endmodule

// File: rtl/aal1_cell_builder.sv
module aal1_cell_builder
  import aal1_cell_pkg::*;
#(
  parameter int ENTRY_W       = 7,
  parameter int BUF_BYTES     = 64,
  parameter int DATA_W        = 8,
  parameter int SEQ_W         = 3,
  parameter int PAYLOAD_BYTES = 47,
  localparam int SEL_W        = (1 << SEQ_W) / 2,
  localparam int ADDR_W       = ENTRY_W + $clog2(BUF_BYTES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cellStart,
  input  logic [SEL_W-1:0]   ptrSelect,
  input  logic [DATA_W-1:0]  ptrValue,
  input  logic [ENTRY_W-1:0] firstEntry,
  input  logic [ENTRY_W-1:0] lastEntry,
  output logic               memReq,
  output logic [ADDR_W-1:0]  memAddr,
  input  logic               memValid,
  input  logic [DATA_W-1:0]  memData,
  output logic               outValid,
  output logic [DATA_W-1:0]  outData,
  output logic               outPtr,
  output logic               outLast,
  output logic               busy,
  output logic [SEQ_W-1:0]   seqNum,
  output logic [ENTRY_W-1:0] curEntry
);

  cellStrobe_t strobe;

  aal1_cell_ctrl #(
    .SEQ_W(SEQ_W), .SEL_W(SEL_W), .PAYLOAD_BYTES(PAYLOAD_BYTES)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cellStart(cellStart), .ptrSelect(ptrSelect),
    .memValid(memValid), .strobe(strobe), .busy(busy), .seqNum(seqNum)
  );

  aal1_cell_datapath #(
    .ENTRY_W(ENTRY_W), .BUF_BYTES(BUF_BYTES), .DATA_W(DATA_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .firstEntry(firstEntry),
    .lastEntry(lastEntry), .ptrValue(ptrValue), .memData(memData),
    .memReq(memReq), .memAddr(memAddr), .outValid(outValid), .outData(outData),
    .outPtr(outPtr), .outLast(outLast), .curEntry(curEntry)
  );

endmodule

// File: rtl/aal1_cell_builder_chk.sv
module aal1_cell_builder_chk #(
  parameter int SEQ_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cellStart,
  input logic             busy,
  input logic [SEQ_W-1:0] seqNum,
  input logic             outValid,
  input logic             outPtr,
  input logic             outLast,
  input logic             memReq
);

  // R1: count steps by one exactly when the final byte leaves
  a_r1_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && outLast) |-> seqNum == $past(seqNum) + SEQ_W'(1));

  // R2: pointer bytes only in even cells
  a_r2_odd_no_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && outPtr) |-> !seqNum[0]);

  // R4: a pointer byte is never the closing byte
  a_r4_ptr_not_last: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && outPtr) |-> !outLast);

  // R8: request is a single-cycle pulse
  a_r8_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    memReq |=> !memReq);

  // R9: an accepted start makes the block busy
  a_r9_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (cellStart && !busy) |=> busy);

  // R10: no output activity while idle
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !memReq);

endmodule

bind aal1_cell_builder aal1_cell_builder_chk #(.SEQ_W(SEQ_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cellStart(cellStart), .busy(busy),
  .seqNum(seqNum), .outValid(outValid), .outPtr(outPtr), .outLast(outLast),
  .memReq(memReq)
);

// File: tb/aal1_cell_builder_test.sv
`timescale 1ns/1ps
module aal1_cell_builder_test;

  localparam int PAYLOAD = 47;
  localparam int WD_CYCLES = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cellStart = 1'b0;
  logic [3:0] ptrSelect = 4'h0;
  logic [7:0] ptrValue = 8'hA5;
  logic [6:0] firstEntry = 7'd0;
  logic [6:0] lastEntry = 7'd0;
  logic       memReq;
  logic [12:0] memAddr;
  logic       memValid = 1'b0;
  logic [7:0] memData = 8'h00;
  logic       outValid, outPtr, outLast, busy;
  logic [7:0] outData;
  logic [2:0] seqNum;
  logic [6:0] curEntry;

  always #2.5 clk = ~clk;

  aal1_cell_builder uut (
    .clk(clk), .rst_n(rst_n), .cellStart(cellStart), .ptrSelect(ptrSelect),
    .ptrValue(ptrValue), .firstEntry(firstEntry), .lastEntry(lastEntry),
    .memReq(memReq), .memAddr(memAddr), .memValid(memValid), .memData(memData),
    .outValid(outValid), .outData(outData), .outPtr(outPtr), .outLast(outLast),
    .busy(busy), .seqNum(seqNum), .curEntry(curEntry)
  );

  int vectors = 0;
  int misses = 0;
  bit done = 1'b0;

  // behavioural reference state
  int mSeq, mCur, mStarted, ptrSeen;
  int mIdx [128];
  int expAddr [$];
  logic [9:0] expByte [$];   // {data, isPtr, isLast}

  function automatic logic [7:0] memFn(input int a);
    return 8'((a * 37 + (a >> 5)) & 255);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // memory responder, latency varies 1..4 cycles
  bit pending = 1'b0;
  int pendAddr, waitCnt, latSeed = 0;
  always @(negedge clk) begin
    memValid = 1'b0;
    if (!rst_n) begin
      pending = 1'b0;
    end else if (pending) begin
      if (waitCnt == 0) begin
        memValid = 1'b1;
        memData  = memFn(pendAddr);
        pending  = 1'b0;
      end else begin
        waitCnt--;
      end
    end else if (memReq) begin
      pending  = 1'b1;
      pendAddr = int'(memAddr);
      waitCnt  = latSeed % 4;
      latSeed++;
    end
  end

  // per-cycle comparison against the queues
  always @(negedge clk) begin
    if (rst_n) begin
      if (memReq) begin
        if (expAddr.size() == 0) check(1'b0, "R8 unexpected memReq", 1, 0);
        else begin
          int e;
          e = expAddr.pop_front();
          check(int'(memAddr) == e, "R6 memAddr", int'(memAddr), e);
        end
      end
      if (outValid) begin
        if (expByte.size() == 0) check(1'b0, "R4 unexpected outValid", 1, 0);
        else begin
          logic [9:0] x;
          x = expByte.pop_front();
          check({outData, outPtr, outLast} == x, "R4/R8 byte{data,ptr,last}",
                int'({outData, outPtr, outLast}), int'(x));
          if (outPtr) ptrSeen++;
        end
      end
    end
  end

  task automatic resetDut(input int first, input int last);
    rst_n = 1'b0;
    firstEntry = 7'(first);
    lastEntry = 7'(last);
    mSeq = 0; mStarted = 0; mCur = 0;
    for (int i = 0; i < 128; i++) mIdx[i] = 0;
    expAddr.delete();
    expByte.delete();
    repeat (3) @(negedge clk);
    check(!busy && !outValid && !memReq, "R10 reset outputs", int'({busy, outValid, memReq}), 0);
    check(seqNum == 3'd0, "R1 reset seqNum", int'(seqNum), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !memReq, "R10 after reset", int'({busy, memReq}), 0);
  endtask

  task automatic runCell(input logic [3:0] sel, input bit pokeBusy);
    bit hasPtr;
    int n, a;
    @(negedge clk);
    ptrSelect = sel;
    cellStart = 1'b1;
    // R2/R3: odd cells never, even cell k uses bit 3-k/2
    hasPtr = (mSeq % 2 == 0) && sel[3 - mSeq / 2];
    n = PAYLOAD;
    if (hasPtr) begin
      expByte.push_back({ptrValue, 2'b10});
      n--;
    end
    if (mStarted == 0) begin
      mCur = int'(firstEntry);
      mStarted = 1;
    end
    for (int i = 0; i < n; i++) begin
      a = mCur * 64 + mIdx[mCur];
      expAddr.push_back(a);
      expByte.push_back({memFn(a), 1'b0, (i == n - 1)});
      mIdx[mCur] = (mIdx[mCur] + 1) % 64;
      mCur = (mCur == int'(lastEntry)) ? int'(firstEntry) : mCur + 1;
    end
    mSeq = (mSeq + 1) % 8;
    @(negedge clk);
    cellStart = 1'b0;
    if (pokeBusy) begin
      // R9: strobe during a cell must be ignored
      repeat (5) @(negedge clk);
      ptrSelect = 4'hF;
      cellStart = 1'b1;
      @(negedge clk);
      cellStart = 1'b0;
    end
    while (busy) @(negedge clk);
    @(negedge clk);
    check(int'(seqNum) == mSeq, "R1 seqNum after cell", int'(seqNum), mSeq);
    check(int'(curEntry) == mCur, "R5 curEntry after cell", int'(curEntry), mCur);
    check(expByte.size() == 0 && expAddr.size() == 0, "R4 cell length",
          expByte.size() + expAddr.size(), 0);
  endtask

  task automatic runPhase(input logic [3:0] sel, input int cells, input int expPtrs, input string tag);
    ptrSeen = 0;
    for (int c = 0; c < cells; c++) runCell(sel, 1'b0);
    check(ptrSeen == expPtrs, tag, ptrSeen, expPtrs);
  endtask

  initial begin
    // three channels, the select patterns in turn
    resetDut(0, 2);
    runPhase(4'h8, 8, 1, "R3 sel 1000 pointer count");
    runPhase(4'hA, 8, 2, "R3 sel 1010 pointer count");
    runPhase(4'hF, 8, 4, "R2/R3 sel 1111 pointer count");
    runPhase(4'h0, 8, 0, "R3 sel 0000 pointer count");
    runPhase(4'h5, 8, 2, "R2 sel 0101 pointer count");
    ptrValue = 8'h3C;
    runCell(4'hF, 1'b1);   // R9 cell 0 with a stray strobe
    runCell(4'h0, 1'b1);   // R9 cell 1
    // single channel, read index wraps past 64 (R6, R7)
    resetDut(5, 5);
    runPhase(4'hF, 12, 6, "R7 single-channel pointer count");
    // 122 channels, entry walk wraps across cells (R5)
    resetDut(3, 124);
    runPhase(4'hA, 16, 4, "R5 wide circuit pointer count");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    #(WD_CYCLES * 5.0);
    if (!done) begin
      misses++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

endmodule